// File: doc/BRIEF.md
# Reshapeable Dual-Port Block Memory

This block is a synchronous dual-port memory built on one fixed storage array. The array holds 16384 data bits plus 2048 side bits. Each port picks its own word shape through a parameter. The narrow shapes (1, 2 and 4 bits) see only the data bits. The byte-oriented shapes (9, 18 and 36 bits) add one side bit to every data byte, which makes 18432 bits in all. A typical use for the side bit is a tag or marker stored next to each byte, such as a start-of-packet flag in a FIFO.

Both ports share one clock. Each port has its own enable, write enable, address, write data and read data. Because the ports may use different shapes, a word written through one port can be read back in pieces, or as part of a larger word, through the other. The block has a fixed policy for same-cycle conflicts. A read always returns the contents from before the edge. When both ports write the same bit in one cycle, port A wins.

Top module: `aspect_ram`

## Requirements
- R1: The width parameter of each port is one of 1, 2, 4, 9, 18 or 36. The address width is 14, 13, 12, 11, 10 or 9 bits, in that order. Every address value is valid, including the top value (4095 at width 4, 2047 at width 9, 1023 at width 18, 511 at width 36).
- R2: A read (enable high, write enable low) puts the addressed word on that port's read data at the next rising clock edge.
- R3: Read data holds its value in any cycle where that port is disabled or writing.
- R4: At width W of 1, 2 or 4, the word at address A occupies data bits A*W to A*W+W-1 of the flat data array. Writes at these widths never change any side bit.
- R5: At width 9, 18 or 36, the port word is laid out as {side bits, data bits}. Data byte k of word A sits at flat data bit A*D+8k, where D is 8, 16 or 32. Its side bit is side bit A*S+k, where S is 1, 2 or 4, and appears at port bit D+k.
- R6: Two ports with different widths read and write the same storage under the mappings of R4 and R5.
- R7: When one port writes a location in the same cycle that the other port reads it, the read returns the old contents.
- R8: When both ports write the same bit in the same cycle, port A's value is stored. Bits written by only one of the two ports keep that port's value.
- R9: While reset is low, both read data outputs are zero. Reset does not change the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset of the read data registers |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | A_AW | Port A word address (14 down to 9 bits per R1) |
| a_din | input | A_WIDTH | Port A write word |
| a_dout | output | A_WIDTH | Port A read word |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | B_AW | Port B word address |
| b_din | input | B_WIDTH | Port B write word |
| b_dout | output | B_WIDTH | Port B read word |

## Verification
The checker assumes that both enables stay low while reset is asserted and that all inputs are known once reset is released. The read-after-write properties only apply when the other port was not writing in the write cycle, because R8 then decides the stored value. The stimulus changes every input on the falling edge and keeps the enables low during each reset. Same-cycle conflicts are applied only in directed tests, where the expected values come from R7 and R8.

// File: rtl/aspect_ram.sv
module aspect_ram #(
  parameter int A_WIDTH = 36,
  parameter int B_WIDTH = 9,
  localparam int A_AW = (A_WIDTH == 1) ? 14 : (A_WIDTH == 2) ? 13 : (A_WIDTH == 4) ? 12 :
                        (A_WIDTH == 9) ? 11 : (A_WIDTH == 18) ? 10 : 9,
  localparam int B_AW = (B_WIDTH == 1) ? 14 : (B_WIDTH == 2) ? 13 : (B_WIDTH == 4) ? 12 :
                        (B_WIDTH == 9) ? 11 : (B_WIDTH == 18) ? 10 : 9
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_en,
  input  logic               a_we,
  input  logic [A_AW-1:0]    a_addr,
  input  logic [A_WIDTH-1:0] a_din,
  output logic [A_WIDTH-1:0] a_dout,
  input  logic               b_en,
  input  logic               b_we,
  input  logic [B_AW-1:0]    b_addr,
  input  logic [B_WIDTH-1:0] b_din,
  output logic [B_WIDTH-1:0] b_dout
);
  localparam int ROWS  = 512;
  localparam int A_DB  = (A_WIDTH >= 9) ? A_WIDTH / 9 * 8 : A_WIDTH;
  localparam int A_SB  = (A_WIDTH >= 9) ? A_WIDTH / 9 : 0;
  localparam int A_SH  = A_AW - 9;
  localparam int B_DB  = (B_WIDTH >= 9) ? B_WIDTH / 9 * 8 : B_WIDTH;
  localparam int B_SB  = (B_WIDTH >= 9) ? B_WIDTH / 9 : 0;
  localparam int B_SH  = B_AW - 9;
  localparam logic [35:0] A_DM = (36'd1 << A_DB) - 36'd1;
  localparam logic [35:0] A_SM = (36'd1 << A_SB) - 36'd1;
  localparam logic [35:0] B_DM = (36'd1 << B_DB) - 36'd1;
  localparam logic [35:0] B_SM = (36'd1 << B_SB) - 36'd1;

  logic [35:0] mem [ROWS];

  logic [13:0] a_ext, b_ext;
  logic [8:0]  a_row, b_row;
  logic [4:0]  a_idx, b_idx, a_doff, b_doff, a_doff_q, b_doff_q;
  logic [1:0]  a_soff, b_soff, a_soff_q, b_soff_q;
  logic [35:0] a_mask, b_mask, a_wval, b_wval, a_q, b_q;
  logic        a_wr, b_wr;

  assign a_ext  = 14'(a_addr);
  assign a_row  = 9'(a_ext >> A_SH);
  assign a_idx  = 5'(a_ext & ((14'd1 << A_SH) - 14'd1));
  assign a_doff = 5'(int'(a_idx) * A_DB);
  assign a_soff = 2'(int'(a_idx) * A_SB);
  assign a_mask = (A_DM << a_doff) | (A_SM << (6'd32 + 6'(a_soff)));
  assign a_wval = ((36'(a_din) & A_DM) << a_doff)
                | (((36'(a_din) >> A_DB) & A_SM) << (6'd32 + 6'(a_soff)));
  assign a_wr   = a_en & a_we;

  assign b_ext  = 14'(b_addr);
  assign b_row  = 9'(b_ext >> B_SH);
  assign b_idx  = 5'(b_ext & ((14'd1 << B_SH) - 14'd1));
  assign b_doff = 5'(int'(b_idx) * B_DB);
  assign b_soff = 2'(int'(b_idx) * B_SB);
  assign b_mask = (B_DM << b_doff) | (B_SM << (6'd32 + 6'(b_soff)));
  assign b_wval = ((36'(b_din) & B_DM) << b_doff)
                | (((36'(b_din) >> B_DB) & B_SM) << (6'd32 + 6'(b_soff)));
  assign b_wr   = b_en & b_we;

  always_ff @(posedge clk) begin
    if (a_wr && b_wr && a_row == b_row) begin
      mem[a_row] <= (mem[a_row] & ~(a_mask | b_mask))
                  | (b_wval & b_mask & ~a_mask)
                  | (a_wval & a_mask);
    end else begin
      if (a_wr) mem[a_row] <= (mem[a_row] & ~a_mask) | (a_wval & a_mask);
      if (b_wr) mem[b_row] <= (mem[b_row] & ~b_mask) | (b_wval & b_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q      <= '0;
      a_doff_q <= '0;
      a_soff_q <= '0;
    end else if (a_en && !a_we) begin
      a_q      <= mem[a_row];
      a_doff_q <= a_doff;
      a_soff_q <= a_soff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q      <= '0;
      b_doff_q <= '0;
      b_soff_q <= '0;
    end else if (b_en && !b_we) begin
      b_q      <= mem[b_row];
      b_doff_q <= b_doff;
      b_soff_q <= b_soff;
    end
  end

  assign a_dout = A_WIDTH'(((a_q >> a_doff_q) & A_DM)
                | (((a_q >> (6'd32 + 6'(a_soff_q))) & A_SM) << A_DB));
  assign b_dout = B_WIDTH'(((b_q >> b_doff_q) & B_DM)
                | (((b_q >> (6'd32 + 6'(b_soff_q))) & B_SM) << B_DB));
endmodule

// File: rtl/aspect_ram_chk.sv
module aspect_ram_chk #(
  parameter int A_WIDTH = 36,
  parameter int B_WIDTH = 9,
  localparam int A_AW = (A_WIDTH == 1) ? 14 : (A_WIDTH == 2) ? 13 : (A_WIDTH == 4) ? 12 :
                        (A_WIDTH == 9) ? 11 : (A_WIDTH == 18) ? 10 : 9,
  localparam int B_AW = (B_WIDTH == 1) ? 14 : (B_WIDTH == 2) ? 13 : (B_WIDTH == 4) ? 12 :
                        (B_WIDTH == 9) ? 11 : (B_WIDTH == 18) ? 10 : 9
)(
  input logic               clk,
  input logic               rst_n,
  input logic               a_en,
  input logic               a_we,
  input logic [A_AW-1:0]    a_addr,
  input logic [A_WIDTH-1:0] a_din,
  input logic [A_WIDTH-1:0] a_dout,
  input logic               b_en,
  input logic               b_we,
  input logic [B_AW-1:0]    b_addr,
  input logic [B_WIDTH-1:0] b_din,
  input logic [B_WIDTH-1:0] b_dout
);
  assert_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_en || a_we) |=> $stable(a_dout));

  assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_en || b_we) |=> $stable(b_dout));

  // R2: a read of the word just written by the same port returns it
  assert_readback_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !a_we && $past(a_en && a_we && !(b_en && b_we)) && a_addr == $past(a_addr))
    |=> a_dout == $past(a_din, 2));

  assert_readback_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && !b_we && $past(b_en && b_we && !(a_en && a_we)) && b_addr == $past(b_addr))
    |=> b_dout == $past(b_din, 2));
endmodule

bind aspect_ram aspect_ram_chk #(.A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout)
);

// File: tb/sim_aspect_ram.sv
module sim_aspect_ram;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic p_en, p_we, q_en, q_we, r_en, r_we, s_en, s_we;
  logic [8:0]  p_addr;  logic [35:0] p_din, p_dout;
  logic [10:0] q_addr;  logic [8:0]  q_din, q_dout;
  logic [11:0] r_addr;  logic [3:0]  r_din, r_dout;
  logic [9:0]  s_addr;  logic [17:0] s_din, s_dout;

  int tests = 0;
  int failed = 0;
  bit ended = 0;

  aspect_ram #(.A_WIDTH(36), .B_WIDTH(9)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_en(p_en), .a_we(p_we), .a_addr(p_addr), .a_din(p_din), .a_dout(p_dout),
    .b_en(q_en), .b_we(q_we), .b_addr(q_addr), .b_din(q_din), .b_dout(q_dout));

  aspect_ram #(.A_WIDTH(4), .B_WIDTH(18)) u1 (
    .clk(clk), .rst_n(rst_n),
    .a_en(r_en), .a_we(r_we), .a_addr(r_addr), .a_din(r_din), .a_dout(r_dout),
    .b_en(s_en), .b_we(s_we), .b_addr(s_addr), .b_din(s_din), .b_dout(s_dout));

  // {port (0 = A x36, 1 = B x9), we, addr[10:0], din[35:0], expected[35:0]}
  localparam int NV = 15;
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, 1'b1, 11'd0,    36'hA_76543210, 36'h0},
    {1'b0, 1'b1, 11'd1,    36'h0_00000000, 36'h0},
    {1'b0, 1'b1, 11'd2,    36'hF_CAFEF00D, 36'h0},
    {1'b0, 1'b1, 11'd3,    36'h0_00000000, 36'h0},
    {1'b0, 1'b1, 11'd511,  36'h5_DEADBEEF, 36'h0},
    {1'b1, 1'b0, 11'd0,    36'h0,          36'h010},
    {1'b1, 1'b0, 11'd1,    36'h0,          36'h132},
    {1'b1, 1'b0, 11'd3,    36'h0,          36'h176},
    {1'b1, 1'b1, 11'd6,    36'h1AB,        36'h0},
    {1'b0, 1'b0, 11'd1,    36'h0,          36'h4_00AB0000},
    {1'b1, 1'b0, 11'd8,    36'h0,          36'h10D},
    {1'b1, 1'b0, 11'd2047, 36'h0,          36'h0DE},
    {1'b1, 1'b0, 11'd2044, 36'h0,          36'h1EF},
    {1'b0, 1'b0, 11'd511,  36'h0,          36'h5_DEADBEEF},
    {1'b1, 1'b0, 11'd11,   36'h0,          36'h1CA}
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  endtask

  task automatic idle_all();
    p_en = 0; q_en = 0; r_en = 0; s_en = 0;
  endtask

  task automatic op_p(input logic we, input logic [8:0] ad, input logic [35:0] d);
    @(negedge clk); p_en = 1; p_we = we; p_addr = ad; p_din = d;
    @(negedge clk); p_en = 0;
  endtask

  task automatic op_q(input logic we, input logic [10:0] ad, input logic [8:0] d);
    @(negedge clk); q_en = 1; q_we = we; q_addr = ad; q_din = d;
    @(negedge clk); q_en = 0;
  endtask

  task automatic op_r(input logic we, input logic [11:0] ad, input logic [3:0] d);
    @(negedge clk); r_en = 1; r_we = we; r_addr = ad; r_din = d;
    @(negedge clk); r_en = 0;
  endtask

  task automatic op_s(input logic we, input logic [9:0] ad, input logic [17:0] d);
    @(negedge clk); s_en = 1; s_we = we; s_addr = ad; s_din = d;
    @(negedge clk); s_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    $display("FAIL watchdog: got timeout expected completion");
    wrap_up();
  end

  initial begin
    rst_n = 0;
    idle_all();
    p_we = 0; q_we = 0; r_we = 0; s_we = 0;
    p_addr = '0; q_addr = '0; r_addr = '0; s_addr = '0;
    p_din = '0; q_din = '0; r_din = '0; s_din = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset A x36", p_dout, 36'h0);
    chk("R9 reset B x9", 36'(q_dout), 36'h0);
    rst_n = 1;

    // R5 / R6 cross-width table, R1 top addresses at entries 11 to 13
    for (int i = 0; i < NV; i++) begin
      logic [84:0] v;
      v = VEC[i];
      if (!v[84]) op_p(v[83], 9'(v[82:72]), v[71:36]);
      else        op_q(v[83], v[82:72], 9'(v[71:36]));
      if (!v[83]) chk("R6 table", v[84] ? 36'(q_dout) : p_dout, v[35:0]);
    end

    // R7: A writes row 2 while B reads byte 0 of it
    @(negedge clk);
    p_en = 1; p_we = 1; p_addr = 9'd2; p_din = 36'h0_11223344;
    q_en = 1; q_we = 0; q_addr = 11'd8;
    @(negedge clk); idle_all();
    chk("R7 read returns old", 36'(q_dout), 36'h10D);
    op_q(0, 11'd8, 9'h0);
    chk("R7 new value later", 36'(q_dout), 36'h044);

    // R8: both ports write row 3 byte 0 in one cycle
    @(negedge clk);
    p_en = 1; p_we = 1; p_addr = 9'd3; p_din = 36'h3_12345678;
    q_en = 1; q_we = 1; q_addr = 11'd12; q_din = 9'h0FF;
    @(negedge clk); idle_all();
    op_q(0, 11'd12, 9'h0);
    chk("R8 port A wins", 36'(q_dout), 36'h178);
    op_p(0, 9'd3, 36'h0);
    chk("R8 full row", p_dout, 36'h3_12345678);

    // R3 and R2
    op_q(0, 11'd0, 9'h0);
    chk("R2 read", 36'(q_dout), 36'h010);
    op_q(1, 11'd0, 9'h1FF);
    chk("R3 hold on write", 36'(q_dout), 36'h010);
    @(negedge clk);
    chk("R3 hold when idle", 36'(q_dout), 36'h010);
    op_q(0, 11'd0, 9'h0);
    chk("R2 read after write", 36'(q_dout), 36'h1FF);

    // R9: reset clears outputs, keeps contents
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R9 reset clears A", p_dout, 36'h0);
    chk("R9 reset clears B", 36'(q_dout), 36'h0);
    rst_n = 1;
    op_q(0, 11'd1, 9'h0);
    chk("R9 contents kept", 36'(q_dout), 36'h132);

    // u1: A x4, B x18
    op_s(1, 10'd0, 18'h3_FFFF);
    op_r(0, 12'd2, 4'h0);
    chk("R4 nibble of x18 word", 36'(r_dout), 36'hF);
    op_r(1, 12'd1, 4'h5);
    op_s(0, 10'd0, 18'h0);
    chk("R4 narrow write keeps side bits", 36'(s_dout), 36'h3_FF5F);
    op_s(1, 10'd1023, 18'h0);
    op_r(1, 12'd4095, 4'hC);
    op_s(0, 10'd1023, 18'h0);
    chk("R1 top address x18 and x4", 36'(s_dout), 36'h0_C000);
    op_r(0, 12'd4095, 4'h0);
    chk("R1 top address x4 read", 36'(r_dout), 36'hC);
    op_s(1, 10'd2, 18'h2_1234);
    op_r(0, 12'd9, 4'h0);
    chk("R5 x18 data at flat bit 36", 36'(r_dout), 36'h3);

    wrap_up();
  end
endmodule